// File: doc/BRIEF.md
# Dual Page-Size TLB Translator

This block turns a 32-bit linear address into a physical address. It keeps two small fully associative translation caches, one for 4 KB pages and one for 4 MB pages, and probes both in the same cycle. When either one hits, the block presents the physical address one cycle later. That address then goes on to the physical tag validity check. When both miss, the block raises a page-walk request. The request carries the current page-directory base value and the linear address. The block then waits for the walker to answer.

The walker answers in one of two ways. It can return a frame number together with a page-size flag. The block then writes the mapping into the cache that matches that size and reports the translated address. Or it can report that no valid mapping exists. The block then signals a page fault. A single directory can hold both page sizes, so any mix of small and large mappings can sit side by side. Writing a new directory base empties both caches.

Top module: `dual_tlb_xlate`

## Requirements
- R1: After reset, `reqReady` is 1 and `hitValid`, `faultValid` and `walkReq` are 0. Every cache entry is empty, so the first access always walks.
- R2: The handshake works as follows. A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. If the 4 KB cache holds tag `lin[31:12]`, `hitValid` is 1 for exactly the next cycle and `hitPhysAddr` = {frame[19:0], lin[11:0]}.
- R3: If the 4 MB cache holds tag `lin[31:22]`, the hit cycle reports `hitPhysAddr` = {frame[19:10], lin[21:0]}. Any address inside that 4 MB region hits.
- R4: If an accepted request misses both caches, `walkReq` rises in the next cycle and stays high until the edge where `walkDone` is sampled. While it is high, `walkLinAddr` holds the request address, `walkBase` shows the directory base, and `reqReady` is 0.
- R5: A walk that completes with `walkFault`=0 gives a `hitValid` pulse in the cycle after `walkDone`. That pulse carries the address built from `walkFrame` and the page size. `walkLarge`=1 selects 4 MB and 0 selects 4 KB. The mapping is written into the cache of that size, so a later access to the same page hits without a walk.
- R6: A walk that completes with `walkFault`=1 gives a one-cycle `faultValid` pulse and no `hitValid`. Nothing is installed, so the same address walks again.
- R7: If both caches hit on the same address, the 4 MB translation is reported.
- R8: Each cache has 4 entries, and each keeps its own round-robin pointer that advances on every install into that cache. The fifth install into a cache overwrites the first one made there. Entries that were not overwritten still hit, and the other cache is untouched.
- R9: A write to the directory base (`dirBaseWe`) loads `walkBase` on that edge. On the next edge it empties every entry of both caches. `reqReady` is 0 during the write cycle and during the cycle after it.
- R10: If a walk result arrives on the same edge as the emptying that follows a base write, the result is still reported on `hitValid`, but it is not installed.
- R11: Each accepted request produces exactly one of `hitValid` or `faultValid`, never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqLinAddr | input | 32 | Linear address to translate |
| reqReady | output | 1 | Block can accept a request this cycle |
| hitValid | output | 1 | One-cycle pulse: `hitPhysAddr` is valid |
| hitPhysAddr | output | 32 | Translated physical address |
| faultValid | output | 1 | One-cycle pulse: walk found no mapping |
| walkReq | output | 1 | Page walk requested, held until `walkDone` |
| walkBase | output | 32 | Page-directory base for the walk |
| walkLinAddr | output | 32 | Linear address being walked |
| walkDone | input | 1 | Walker answer present (sampled while `walkReq` is 1) |
| walkFault | input | 1 | Walker found no valid mapping |
| walkLarge | input | 1 | 1 = 4 MB page, 0 = 4 KB page |
| walkFrame | input | 20 | Physical frame number; bits 19:10 are used for 4 MB pages |
| dirBaseWe | input | 1 | Write strobe for the directory base register |
| dirBaseData | input | 32 | New directory base value |

## Verification
A wrong internal state in this block always shows up at the ports. Each case below names what the outside sees and how soon.

- A stale or missing valid bit makes an access that should hit raise `walkReq` instead, or makes an access that should walk hit. Either shows up in the cycle after acceptance.
- A wrong round-robin pointer overwrites the wrong entry. This appears only later, when a victim that should have survived walks again, or one that should be gone still hits.
- A wrong priority between the two caches shows up directly on `hitPhysAddr` in the hit cycle.
- A flush that comes late or is lost appears as a hit on the first access after a base write.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int ADDR_W      = 32;
  localparam int SMALL_OFS   = 12;
  localparam int LARGE_OFS   = 22;
  localparam int SMALL_TAG_W = ADDR_W - SMALL_OFS;
  localparam int LARGE_TAG_W = ADDR_W - LARGE_OFS;
  localparam int FRAME_W     = SMALL_TAG_W;

  typedef enum logic { ST_IDLE, ST_WALK } xlate_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch request address
    logic loadHit;      // load result from lookup
    logic loadWalk;     // load result from walker answer
    logic install;      // write walker answer into a cache
    logic installLarge; // 1: 4 MB cache, 0: 4 KB cache
    logic flush;        // empty both caches
  } dp_strobe_t;
endpackage

// File: rtl/dtlb_array.sv
module dtlb_array #(
  parameter int TAG_W   = 20,
  parameter int FRAME_W = 20,
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TAG_W-1:0]   lookupTag,
  output logic               hit,
  output logic [FRAME_W-1:0] hitFrame,
  input  logic               flush,
  input  logic               wrEn,
  input  logic [TAG_W-1:0]   wrTag,
  input  logic [FRAME_W-1:0] wrFrame
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ   [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];
  logic [PTR_W-1:0]   ptrQ;
  logic [ENTRIES-1:0] matchVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign matchVec[i] = validQ[i] && (tagQ[i] == lookupTag);
  end

  always_comb begin
    hit      = |matchVec;
    hitFrame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitFrame = hitFrame | frameQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      ptrQ   <= '0;
    end else if (flush) begin
      validQ <= '0;
    end else if (wrEn) begin
      validQ[ptrQ] <= 1'b1;
      ptrQ         <= (ptrQ == LAST_PTR) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && !flush) begin
      tagQ[ptrQ]   <= wrTag;
      frameQ[ptrQ] <= wrFrame;
    end
  end
endmodule

// File: rtl/dtlb_data.sv
module dtlb_data
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_strobe_t         stb,
  input  logic [ADDR_W-1:0]  reqLinAddr,
  input  logic               dirBaseWe,
  input  logic [ADDR_W-1:0]  dirBaseData,
  input  logic [FRAME_W-1:0] walkFrame,
  output logic               anyHit,
  output logic [ADDR_W-1:0]  physAddr,
  output logic [ADDR_W-1:0]  walkBase,
  output logic [ADDR_W-1:0]  walkLinAddr
);
  localparam int LFRAME_W = LARGE_TAG_W;

  logic [ADDR_W-1:0]   dirBaseQ, linQ, physQ;
  logic                smallHit, largeHit;
  logic [FRAME_W-1:0]  smallFrame;
  logic [LFRAME_W-1:0] largeFrame;
  logic [ADDR_W-1:0]   lookPhys, fillPhys;
  logic [LFRAME_W-1:0] walkFrameHi;

  assign walkFrameHi = walkFrame[FRAME_W-1 -: LFRAME_W];

  dtlb_array #(.TAG_W(SMALL_TAG_W), .FRAME_W(FRAME_W), .ENTRIES(ENTRIES)) u_small (
    .clk      (clk),
    .rstN     (rstN),
    .lookupTag(reqLinAddr[ADDR_W-1:SMALL_OFS]),
    .hit      (smallHit),
    .hitFrame (smallFrame),
    .flush    (stb.flush),
    .wrEn     (stb.install && !stb.installLarge),
    .wrTag    (linQ[ADDR_W-1:SMALL_OFS]),
    .wrFrame  (walkFrame)
  );

  dtlb_array #(.TAG_W(LARGE_TAG_W), .FRAME_W(LFRAME_W), .ENTRIES(ENTRIES)) u_large (
    .clk      (clk),
    .rstN     (rstN),
    .lookupTag(reqLinAddr[ADDR_W-1:LARGE_OFS]),
    .hit      (largeHit),
    .hitFrame (largeFrame),
    .flush    (stb.flush),
    .wrEn     (stb.install && stb.installLarge),
    .wrTag    (linQ[ADDR_W-1:LARGE_OFS]),
    .wrFrame  (walkFrameHi)
  );

  // large page wins when both caches match
  always_comb begin
    if (largeHit) lookPhys = {largeFrame, reqLinAddr[LARGE_OFS-1:0]};
    else          lookPhys = {smallFrame, reqLinAddr[SMALL_OFS-1:0]};
    if (stb.installLarge) fillPhys = {walkFrameHi, linQ[LARGE_OFS-1:0]};
    else                  fillPhys = {walkFrame, linQ[SMALL_OFS-1:0]};
  end

  assign anyHit = smallHit || largeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirBaseQ <= '0;
      linQ     <= '0;
      physQ    <= '0;
    end else begin
      if (dirBaseWe)        dirBaseQ <= dirBaseData;
      if (stb.capture)      linQ     <= reqLinAddr;
      if (stb.loadHit)      physQ    <= lookPhys;
      else if (stb.loadWalk) physQ   <= fillPhys;
    end
  end

  assign physAddr    = physQ;
  assign walkBase    = dirBaseQ;
  assign walkLinAddr = linQ;
endmodule

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       dirBaseWe,
  input  logic       anyHit,
  input  logic       walkDone,
  input  logic       walkFault,
  input  logic       walkLarge,
  output dp_strobe_t stb,
  output logic       reqReady,
  output logic       walkReq,
  output logic       hitValid,
  output logic       faultValid
);
  xlate_state_e stateQ, stateD;
  logic flushPendQ;
  logic accept, walkAns, walkOk;

  assign reqReady = (stateQ == ST_IDLE) && !flushPendQ && !dirBaseWe;
  assign accept   = reqValid && reqReady;
  assign walkAns  = (stateQ == ST_WALK) && walkDone;
  assign walkOk   = walkAns && !walkFault;

  always_comb begin
    stb              = '0;
    stb.capture      = accept;
    stb.loadHit      = accept && anyHit;
    stb.loadWalk     = walkOk;
    stb.install      = walkOk && !flushPendQ;
    stb.installLarge = walkLarge;
    stb.flush        = flushPendQ;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (accept && !anyHit) stateD = ST_WALK;
      ST_WALK: if (walkDone)          stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      flushPendQ <= 1'b0;
      hitValid   <= 1'b0;
      faultValid <= 1'b0;
    end else begin
      stateQ     <= stateD;
      flushPendQ <= dirBaseWe;
      hitValid   <= (accept && anyHit) || walkOk;
      faultValid <= walkAns && walkFault;
    end
  end

  assign walkReq = (stateQ == ST_WALK);
endmodule

// File: rtl/dual_tlb_xlate.sv
module dual_tlb_xlate
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqLinAddr,
  output logic        reqReady,
  output logic        hitValid,
  output logic [31:0] hitPhysAddr,
  output logic        faultValid,
  output logic        walkReq,
  output logic [31:0] walkBase,
  output logic [31:0] walkLinAddr,
  input  logic        walkDone,
  input  logic        walkFault,
  input  logic        walkLarge,
  input  logic [19:0] walkFrame,
  input  logic        dirBaseWe,
  input  logic [31:0] dirBaseData
);
  dp_strobe_t stb;
  logic anyHit;

  dtlb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .dirBaseWe (dirBaseWe),
    .anyHit    (anyHit),
    .walkDone  (walkDone),
    .walkFault (walkFault),
    .walkLarge (walkLarge),
    .stb       (stb),
    .reqReady  (reqReady),
    .walkReq   (walkReq),
    .hitValid  (hitValid),
    .faultValid(faultValid)
  );

  dtlb_data #(.ENTRIES(ENTRIES)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqLinAddr (reqLinAddr),
    .dirBaseWe  (dirBaseWe),
    .dirBaseData(dirBaseData),
    .walkFrame  (walkFrame),
    .anyHit     (anyHit),
    .physAddr   (hitPhysAddr),
    .walkBase   (walkBase),
    .walkLinAddr(walkLinAddr)
  );
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqLinAddr,
  input logic        reqReady,
  input logic        hitValid,
  input logic [31:0] hitPhysAddr,
  input logic        faultValid,
  input logic        walkReq,
  input logic [31:0] walkBase,
  input logic [31:0] walkLinAddr,
  input logic        walkDone,
  input logic        walkFault,
  input logic        walkLarge,
  input logic [19:0] walkFrame,
  input logic        dirBaseWe,
  input logic [31:0] dirBaseData
);
  p_result_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(hitValid && faultValid));

  p_accept_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (hitValid || walkReq));

  p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && !walkDone) |=> (walkReq && $stable(walkLinAddr)));

  p_walk_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> !reqReady);

  p_walk_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && walkDone && !walkFault) |=> (hitValid && !walkReq));

  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && walkDone && walkFault) |=> (faultValid && !hitValid));

  p_base_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    dirBaseWe |=> (walkBase == $past(dirBaseData) && !reqReady));
endmodule

bind dual_tlb_xlate dtlb_checker u_chk (.*);

// File: tb/dual_tlb_xlate_bench.sv
module dual_tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqLinAddr;
  logic        reqReady;
  logic        hitValid;
  logic [31:0] hitPhysAddr;
  logic        faultValid;
  logic        walkReq;
  logic [31:0] walkBase;
  logic [31:0] walkLinAddr;
  logic        walkDone;
  logic        walkFault;
  logic        walkLarge;
  logic [19:0] walkFrame;
  logic        dirBaseWe;
  logic [31:0] dirBaseData;

  int checks = 0;
  int fails  = 0;
  logic [31:0] curBase;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_tlb_xlate u_dual_tlb_xlate (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // one translation; the caller supplies the expected outcome
  task automatic access(input logic [31:0] lin, input bit expHit,
                        input logic [31:0] expPhys, input bit wFault,
                        input bit wLarge, input logic [19:0] wFrame,
                        input bit midFlush, input logic [31:0] newBase,
                        input string req);
    while (!reqReady) @(negedge clk);
    reqValid   = 1'b1;
    reqLinAddr = lin;
    @(negedge clk);
    reqValid = 1'b0;
    if (expHit) begin
      check(hitValid === 1'b1, req, "hitValid on hit", 32'(hitValid), 32'd1);
      check(hitPhysAddr === expPhys, req, "hit address", hitPhysAddr, expPhys);
      check(walkReq === 1'b0 && faultValid === 1'b0, req, "no walk on hit",
            {30'd0, walkReq, faultValid}, 32'd0);
      @(negedge clk);
      check(hitValid === 1'b0, req, "hit pulse width", 32'(hitValid), 32'd0);
    end else begin
      check(walkReq === 1'b1 && hitValid === 1'b0, req, "walk raised on miss",
            {30'd0, walkReq, hitValid}, 32'd2);
      check(walkLinAddr === lin, "R4", "walk linear address", walkLinAddr, lin);
      check(walkBase === curBase, "R4", "walk base", walkBase, curBase);
      check(reqReady === 1'b0, "R4", "busy during walk", 32'(reqReady), 32'd0);
      @(negedge clk);
      check(walkReq === 1'b1, "R4", "walk held", 32'(walkReq), 32'd1);
      if (midFlush) begin
        dirBaseWe   = 1'b1;
        dirBaseData = newBase;
        curBase     = newBase;
        @(negedge clk);
        dirBaseWe = 1'b0;
      end
      walkDone  = 1'b1;
      walkFault = wFault;
      walkLarge = wLarge;
      walkFrame = wFrame;
      @(negedge clk);
      walkDone = 1'b0;
      if (wFault) begin
        check(faultValid === 1'b1 && hitValid === 1'b0, "R6", "fault pulse",
              {30'd0, faultValid, hitValid}, 32'd2);
      end else begin
        check(hitValid === 1'b1 && faultValid === 1'b0, req, "walk result valid",
              {30'd0, hitValid, faultValid}, 32'd2);
        check(hitPhysAddr === expPhys, req, "walk result address", hitPhysAddr, expPhys);
      end
      check(walkReq === 1'b0, req, "walk dropped", 32'(walkReq), 32'd0);
      @(negedge clk);
      check(hitValid === 1'b0 && faultValid === 1'b0, "R11", "single result",
            {30'd0, hitValid, faultValid}, 32'd0);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    dirBaseWe   = 1'b1;
    dirBaseData = b;
    #1;
    check(reqReady === 1'b0, "R9", "ready low in write cycle", 32'(reqReady), 32'd0);
    @(negedge clk);
    dirBaseWe = 1'b0;
    curBase   = b;
    check(reqReady === 1'b0, "R9", "ready low after write", 32'(reqReady), 32'd0);
    check(walkBase === b, "R9", "base loaded", walkBase, b);
    @(negedge clk);
    check(reqReady === 1'b1, "R9", "ready back", 32'(reqReady), 32'd1);
  endtask

  task automatic t_reset();
    check(reqReady === 1'b1, "R1", "reqReady", 32'(reqReady), 32'd1);
    check(hitValid === 1'b0 && faultValid === 1'b0 && walkReq === 1'b0, "R1",
          "outputs idle", {29'd0, hitValid, faultValid, walkReq}, 32'd0);
    set_base(32'h1111_1000);
    // R1: empty caches, first access walks; R5 small install
    access(32'h1234_5678, 0, 32'hABCD_E678, 0, 0, 20'hABCDE, 0, 0, "R1");
  endtask

  task automatic t_small_hit();
    access(32'h1234_5ABC, 1, 32'hABCD_EABC, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_large();
    access(32'h0AC1_2345, 0, 32'h5541_2345, 0, 1, 20'h55400, 0, 0, "R5");
    access(32'h0AFF_FFFF, 1, 32'h557F_FFFF, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_fault();
    access(32'h7000_0000, 0, 0, 1, 0, 0, 0, 0, "R6");
    access(32'h7000_0000, 0, 32'h0011_1000, 0, 0, 20'h00111, 0, 0, "R6");
  endtask

  task automatic t_priority();
    access(32'h4000_1000, 0, 32'h2222_2000, 0, 0, 20'h22222, 0, 0, "R5");
    access(32'h4000_2000, 0, 32'h33C0_2000, 0, 1, 20'h33C00, 0, 0, "R5");
    access(32'h4000_1004, 1, 32'h33C0_1004, 0, 0, 0, 0, 0, "R7");
  endtask

  task automatic t_round_robin();
    // small cache holds 12345,70000,40001; two more installs wrap and evict 12345
    access(32'h5000_0000, 0, 32'h0A05_0000, 0, 0, 20'h0A050, 0, 0, "R8");
    access(32'h5100_0000, 0, 32'h0A05_1000, 0, 0, 20'h0A051, 0, 0, "R8");
    access(32'h1234_5000, 0, 32'hABCD_E000, 0, 0, 20'hABCDE, 0, 0, "R8");
    access(32'h5000_0123, 1, 32'h0A05_0123, 0, 0, 0, 0, 0, "R8");
    access(32'h7000_0000, 0, 0, 1, 0, 0, 0, 0, "R8");
    access(32'h0AC0_0000, 1, 32'h5540_0000, 0, 0, 0, 0, 0, "R8");
  endtask

  task automatic t_flush();
    set_base(32'h00AB_C000);
    access(32'h5000_0123, 0, 0, 1, 0, 0, 0, 0, "R9");
    access(32'h0AC0_0000, 0, 0, 1, 0, 0, 0, 0, "R9");
  endtask

  task automatic t_flush_vs_install();
    access(32'h6000_0000, 0, 32'h0600_0000, 0, 0, 20'h06000, 1, 32'h2222_2000, "R10");
    access(32'h6000_0000, 0, 0, 1, 0, 0, 0, 0, "R10");
  endtask

  initial begin
    rstN = 1'b0; reqValid = 0; reqLinAddr = 0; walkDone = 0; walkFault = 0;
    walkLarge = 0; walkFrame = 0; dirBaseWe = 0; dirBaseData = 0; curBase = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_hit();
    t_large();
    t_fault();
    t_priority();
    t_round_robin();
    t_flush();
    t_flush_vs_install();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule